// File: doc/BRIEF.md
# Per-Port Statistics Snapshot Reader

This block keeps a bank of event counters for every port of a switch. Each counter advances by one on its own increment pulse and wraps at its width. Software does not read the live counters directly. It first issues a capture command that freezes every counter of one port into a shadow bank in a single clock edge. It then fetches the frozen values one at a time by issuing indexed read commands, and it collects each result from two 16-bit data registers.

Software talks to the block through a small register window. Offset 0x1D is the operation register. Writing to it starts a command, and bit 15 of its read value is the busy flag. Offset 0x1E holds the upper 16 bits of the last result and offset 0x1F holds the lower 16 bits. After each accepted command the busy flag stays set for a fixed number of cycles, and software must wait for it to clear before it writes again.

A parameter can join counters in pairs to form 64-bit statistics. In a joined pair the lower index holds the low half and the next index holds the high half. The high half advances only on the carry out of the low half.

Top module: `stat_snapshot_reader`

## Requirements
- R1: After reset, every live counter, the shadow bank and both data registers are zero, and the busy flag is clear.
- R2: A read at offset 0x1D returns the busy flag in bit 15 and zeros in bits 14:0. Offset 0x1E returns result bits 31:16, offset 0x1F returns result bits 15:0, and any other offset returns zero.
- R3: Writing 0xDC in bits 15:8 of offset 0x1D, with a port number in bits 7:0, copies all counters of that port into the shadow bank on the accepting edge. The copy holds the values from before that edge's increments. Later counting leaves the shadow bank unchanged until the next capture.
- R4: Writing 0xCC in bits 15:8 of offset 0x1D, with a counter index in bits 7:0, loads that shadow counter, zero-extended to 32 bits, into the two data registers.
- R5: An accepted command keeps busy set for exactly BUSY_CYCLES cycles. The data registers of a read change on the edge that clears busy and at no other time.
- R6: The block ignores three kinds of write: a write made while busy is set, a write to offset 0x1D whose bits 15:8 are neither 0xDC nor 0xCC, and a write to any other offset. None of them changes busy, the data registers or the shadow bank.
- R7: A capture of a port number at or above NUM_PORTS completes normally and fills the shadow bank with zeros. A read of an index at or above NUM_CTRS completes normally and returns zero.
- R8: Each live counter adds one per cycle in which its increment pulse is high, and it wraps modulo 2^CTR_W.
- R9: When bit j of PAIR_MASK is set, counter 2j+1 ignores its own pulse and adds one only when counter 2j wraps. Reading index 2j then gives the low half and reading index 2j+1 gives the high half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inc_i | input | NUM_PORTS*NUM_CTRS | Increment pulses, bit p*NUM_CTRS+c for counter c of port p |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Register write offset |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 5 | Register read offset |
| rd_data_o | output | 16 | Register read data, combinational |

## Verification
The assertions assume that increment pulses and register writes are stable synchronous levels around each rising edge. The checker derives command acceptance from the write port alone, so it also assumes that the same edge sees only one write. The bench changes every input on the falling edge and holds each write strobe for exactly one cycle. It sends commands both while busy and while idle so that it covers the cases where a write is ignored and the cases where it is accepted.

// File: rtl/stat_snap_pkg.sv
package stat_snap_pkg;
    localparam logic [4:0] ADDR_OP   = 5'h1D;
    localparam logic [4:0] ADDR_HI   = 5'h1E;
    localparam logic [4:0] ADDR_LO   = 5'h1F;
    localparam logic [7:0] CODE_SNAP = 8'hDC;
    localparam logic [7:0] CODE_READ = 8'hCC;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_SNAP = 2'd1,
        OP_READ = 2'd2
    } op_kind_e;

    typedef struct packed {
        op_kind_e   kind;
        logic [7:0] arg;
    } stat_cmd_t;

    function automatic stat_cmd_t decode_cmd(input logic [15:0] word);
        stat_cmd_t c;
        c.arg = word[7:0];
        if (word[15:8] == CODE_SNAP)      c.kind = OP_SNAP;
        else if (word[15:8] == CODE_READ) c.kind = OP_READ;
        else                              c.kind = OP_NONE;
        return c;
    endfunction
endpackage

// File: rtl/stat_live_bank.sv
module stat_live_bank #(
    parameter int NUM_PORTS = 4,
    parameter int NUM_CTRS  = 8,
    parameter int CTR_W     = 32,
    parameter int NUM_PAIRS = NUM_CTRS / 2,
    parameter logic [NUM_PAIRS-1:0] PAIR_MASK = '0
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [NUM_PORTS*NUM_CTRS-1:0]       inc_i,
    output logic [NUM_PORTS*NUM_CTRS*CTR_W-1:0] live_o
);
    localparam logic [CTR_W-1:0] CTR_MAX = '1;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        for (genvar c = 0; c < NUM_CTRS; c++) begin : g_ctr
            localparam int SLOT = p * NUM_CTRS + c;
            logic             step;
            logic [CTR_W-1:0] cnt_q;

            if ((c % 2) == 1) begin : g_odd
                if (PAIR_MASK[c/2]) begin : g_high
                    assign step = inc_i[SLOT-1] &&
                                  (live_o[(SLOT-1)*CTR_W +: CTR_W] == CTR_MAX);
                end else begin : g_plain
                    assign step = inc_i[SLOT];
                end
            end else begin : g_even
                assign step = inc_i[SLOT];
            end

            always_ff @(posedge clk) begin
                if (rst)       cnt_q <= '0;
                else if (step) cnt_q <= cnt_q + 1'b1;
            end

            assign live_o[SLOT*CTR_W +: CTR_W] = cnt_q;
        end
    end
endmodule

// File: rtl/stat_snap_bank.sv
module stat_snap_bank #(
    parameter int NUM_PORTS = 4,
    parameter int NUM_CTRS  = 8,
    parameter int CTR_W     = 32
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                cap_en_i,
    input  logic [7:0]                          cap_port_i,
    input  logic [NUM_PORTS*NUM_CTRS*CTR_W-1:0] live_i,
    input  logic [7:0]                          idx_i,
    output logic [NUM_CTRS*CTR_W-1:0]           snap_o,
    output logic [31:0]                         sel_o
);
    localparam int BANK_W = NUM_CTRS * CTR_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_o <= '0;
        end else if (cap_en_i) begin
            snap_o <= '0;
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (cap_port_i == 8'(p)) snap_o <= live_i[p*BANK_W +: BANK_W];
            end
        end
    end

    always_comb begin
        sel_o = '0;
        for (int c = 0; c < NUM_CTRS; c++) begin
            if (idx_i == 8'(c)) sel_o[CTR_W-1:0] = snap_o[c*CTR_W +: CTR_W];
        end
    end
endmodule

// File: rtl/stat_cmd_ctrl.sv
module stat_cmd_ctrl
    import stat_snap_pkg::*;
#(
    parameter int BUSY_CYCLES = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en_i,
    input  logic [4:0]  wr_addr_i,
    input  logic [15:0] wr_data_i,
    input  logic [31:0] sel_i,
    output logic        cap_en_o,
    output logic [7:0]  cap_port_o,
    output logic [7:0]  rd_idx_o,
    output logic        busy_o,
    output logic [15:0] hi_o,
    output logic [15:0] lo_o
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    stat_cmd_t        cmd;
    logic             accept;
    logic [CNT_W-1:0] busy_cnt;
    logic             pend_read;
    logic [7:0]       idx_q;

    assign cmd    = decode_cmd(wr_data_i);
    assign busy_o = (busy_cnt != '0);
    assign accept = wr_en_i && (wr_addr_i == ADDR_OP) && !busy_o && (cmd.kind != OP_NONE);

    assign cap_en_o   = accept && (cmd.kind == OP_SNAP);
    assign cap_port_o = cmd.arg;
    assign rd_idx_o   = idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_cnt  <= '0;
            pend_read <= 1'b0;
            idx_q     <= '0;
            hi_o      <= '0;
            lo_o      <= '0;
        end else if (accept) begin
            busy_cnt  <= CNT_W'(BUSY_CYCLES);
            pend_read <= (cmd.kind == OP_READ);
            idx_q     <= cmd.arg;
        end else if (busy_o) begin
            busy_cnt <= busy_cnt - 1'b1;
            if (busy_cnt == CNT_W'(1) && pend_read) begin
                hi_o      <= sel_i[31:16];
                lo_o      <= sel_i[15:0];
                pend_read <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/stat_snapshot_reader.sv
module stat_snapshot_reader
    import stat_snap_pkg::*;
#(
    parameter int NUM_PORTS   = 4,
    parameter int NUM_CTRS    = 8,
    parameter int CTR_W       = 32,
    parameter int BUSY_CYCLES = 3,
    parameter int NUM_PAIRS   = NUM_CTRS / 2,
    parameter logic [NUM_PAIRS-1:0] PAIR_MASK = '0
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_PORTS*NUM_CTRS-1:0] inc_i,
    input  logic                          wr_en_i,
    input  logic [4:0]                    wr_addr_i,
    input  logic [15:0]                   wr_data_i,
    input  logic [4:0]                    rd_addr_i,
    output logic [15:0]                   rd_data_o
);
    localparam int LIVE_W = NUM_PORTS * NUM_CTRS * CTR_W;
    localparam int SNAP_W = NUM_CTRS * CTR_W;

    logic [LIVE_W-1:0] live_flat;
    logic [SNAP_W-1:0] snap_flat;
    logic [31:0]       sel_val;
    logic              cap_en;
    logic [7:0]        cap_port;
    logic [7:0]        rd_idx;
    logic              busy;
    logic [15:0]       data_hi;
    logic [15:0]       data_lo;

    stat_live_bank #(
        .NUM_PORTS(NUM_PORTS), .NUM_CTRS(NUM_CTRS), .CTR_W(CTR_W),
        .NUM_PAIRS(NUM_PAIRS), .PAIR_MASK(PAIR_MASK)
    ) live_i (
        .clk(clk), .rst(rst), .inc_i(inc_i), .live_o(live_flat)
    );

    stat_snap_bank #(
        .NUM_PORTS(NUM_PORTS), .NUM_CTRS(NUM_CTRS), .CTR_W(CTR_W)
    ) snap_i (
        .clk(clk), .rst(rst), .cap_en_i(cap_en), .cap_port_i(cap_port),
        .live_i(live_flat), .idx_i(rd_idx), .snap_o(snap_flat), .sel_o(sel_val)
    );

    stat_cmd_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) ctrl_i (
        .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .sel_i(sel_val), .cap_en_o(cap_en),
        .cap_port_o(cap_port), .rd_idx_o(rd_idx), .busy_o(busy),
        .hi_o(data_hi), .lo_o(data_lo)
    );

    always_comb begin
        case (rd_addr_i)
            ADDR_OP: rd_data_o = {busy, 15'b0};
            ADDR_HI: rd_data_o = data_hi;
            ADDR_LO: rd_data_o = data_lo;
            default: rd_data_o = '0;
        endcase
    end
endmodule

// File: rtl/stat_snapshot_reader_chk.sv
module stat_snapshot_reader_chk
    import stat_snap_pkg::*;
#(
    parameter int BUSY_CYCLES = 3,
    parameter int SNAP_W      = 256
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [4:0]        wr_addr,
    input logic [15:0]       wr_data,
    input logic              busy,
    input logic              cap_en,
    input logic [SNAP_W-1:0] snap,
    input logic [15:0]       hi,
    input logic [15:0]       lo
);
    logic [15:0] run;

    always_ff @(posedge clk) begin
        if (rst)       run <= '0;
        else if (busy) run <= run + 1'b1;
        else           run <= '0;
    end

    a_r5_busy_len: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run == 16'(BUSY_CYCLES)));

    a_r5_busy_max: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run < 16'(BUSY_CYCLES)));

    a_r5_accept_busy: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_OP && !busy &&
         (wr_data[15:8] == CODE_SNAP || wr_data[15:8] == CODE_READ)) |=> busy);

    a_r5_data_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable({hi, lo}));

    a_r3_snap_frozen: assert property (@(posedge clk) disable iff (rst)
        !cap_en |=> $stable(snap));

    a_r6_busy_no_cap: assert property (@(posedge clk) disable iff (rst)
        busy |-> !cap_en);
endmodule

bind stat_snapshot_reader stat_snapshot_reader_chk #(
    .BUSY_CYCLES(BUSY_CYCLES), .SNAP_W(SNAP_W)
) chk_i (
    .clk(clk), .rst(rst), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
    .wr_data(wr_data_i), .busy(busy), .cap_en(cap_en), .snap(snap_flat),
    .hi(data_hi), .lo(data_lo)
);

// File: tb/stat_snapshot_reader_tb_top.sv
module stat_snapshot_reader_tb_top;
    localparam int NP = 4;
    localparam int NC = 8;
    localparam int CW = 10;
    localparam int BC = 3;
    localparam logic [NC/2-1:0] PM = 4'b0001;
    localparam int unsigned MASK = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP*NC-1:0] inc = '0;
    logic          wr_en = 1'b0;
    logic [4:0]    wr_addr = '0;
    logic [15:0]   wr_data = '0;
    logic [4:0]    rd_addr = '0;
    logic [15:0]   rd_data;

    int unsigned model [NP][NC];
    int unsigned snap [NC];
    int unsigned bbusy;
    bit          pend;
    int unsigned pidx;
    int unsigned exp_hi, exp_lo;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5ns clk = ~clk;

    stat_snapshot_reader #(
        .NUM_PORTS(NP), .NUM_CTRS(NC), .CTR_W(CW), .BUSY_CYCLES(BC),
        .NUM_PAIRS(NC/2), .PAIR_MASK(PM)
    ) dut_i (
        .clk(clk), .rst(rst), .inc_i(inc), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
    );

    function automatic bit is_high(int c);
        return (c % 2 == 1) && PM[c/2];
    endfunction

    task automatic model_edge();
        int unsigned old [NP][NC];
        old = model;
        if (rst) begin
            foreach (model[p, c]) model[p][c] = 0;
            foreach (snap[c]) snap[c] = 0;
            bbusy = 0; pend = 0; exp_hi = 0; exp_lo = 0;
            return;
        end
        if (wr_en && wr_addr == 5'h1D && bbusy == 0 &&
            (wr_data[15:8] == 8'hDC || wr_data[15:8] == 8'hCC)) begin
            bbusy = BC;
            if (wr_data[15:8] == 8'hDC) begin
                for (int c = 0; c < NC; c++)
                    snap[c] = (wr_data[7:0] < NP) ? old[wr_data[7:0]][c] : 0;
                pend = 0;
            end else begin
                pend = 1; pidx = wr_data[7:0];
            end
        end else if (bbusy > 0) begin
            if (bbusy == 1 && pend) begin
                int unsigned v;
                v = (pidx < NC) ? snap[pidx] : 0;
                exp_hi = v >> 16; exp_lo = v & 16'hFFFF; pend = 0;
            end
            bbusy--;
        end
        for (int p = 0; p < NP; p++)
            for (int c = 0; c < NC; c++) begin
                if (is_high(c)) begin
                    if (inc[p*NC+c-1] && old[p][c-1] == MASK) model[p][c] = (old[p][c] + 1) & MASK;
                end else if (inc[p*NC+c]) begin
                    model[p][c] = (old[p][c] + 1) & MASK;
                end
            end
    endtask

    task automatic cycle();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic chk(string req, int unsigned act, int unsigned exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] a, output int unsigned v);
        rd_addr = a; #0.1ns; v = rd_data;
    endtask

    task automatic write(input logic [4:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cycle();
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        while (bbusy != 0) cycle();
    endtask

    task automatic read_check(string req, int unsigned idx);
        int unsigned h, l;
        write(5'h1D, 16'hCC00 | 16'(idx));
        wait_idle();
        rd(5'h1E, h); rd(5'h1F, l);
        chk(req, {h[15:0], l[15:0]}, (exp_hi << 16) | exp_lo);
    endtask

    task automatic pulse(int p, int c, int n);
        for (int i = 0; i < n; i++) begin
            inc[p*NC+c] = 1'b1; cycle();
        end
        inc = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int unsigned v, h, l;
        void'($urandom(32'd2024));
        @(negedge clk);
        repeat (3) cycle();
        rst = 1'b0;
        cycle();

        // R1, R2: reset state and register window
        rd(5'h1D, v); chk("R1 busy after reset", v, 0);
        rd(5'h1E, v); chk("R1 hi after reset", v, 0);
        rd(5'h1F, v); chk("R1 lo after reset", v, 0);
        read_check("R1 shadow zero after reset", 2);

        // R8: plain counting, R5 busy timing
        pulse(2, 5, 7);
        write(5'h1D, 16'hDC02);
        rd(5'h1D, v); chk("R5 busy set after accept", v, 16'h8000);
        for (int i = 0; i < BC - 1; i++) cycle();
        rd(5'h1D, v); chk("R5 busy held", v, 16'h8000);
        cycle();
        rd(5'h1D, v); chk("R5 busy cleared", v, 0);
        read_check("R4 read counter 5 of port 2", 5);
        chk("R8 count value", exp_lo, 7);

        // R3: frozen shadow under further counting
        pulse(2, 5, 4);
        read_check("R3 shadow frozen", 5);
        chk("R3 frozen value", exp_lo, 7);

        // R6: writes during busy and bad codes ignored
        rd(5'h1E, h); rd(5'h1F, l);
        write(5'h1D, 16'hDC02);
        write(5'h1D, 16'hCC05);
        write(5'h1E, 16'hCC05);
        wait_idle();
        rd(5'h1E, v); chk("R6 hi unchanged after busy write", v, h);
        rd(5'h1F, v); chk("R6 lo unchanged after busy write", v, l);
        write(5'h1D, 16'h1234);
        rd(5'h1D, v); chk("R6 unknown code ignored", v, 0);
        write(5'h0C, 16'hDC01);
        rd(5'h1D, v); chk("R6 other offset ignored", v, 0);
        rd(5'h05, v); chk("R2 unused offset reads zero", v, 0);
        read_check("R3 shadow after recapture", 5);
        chk("R3 recaptured value", exp_lo, 11);

        // R7: out of range port and index
        write(5'h1D, 16'hDC07); wait_idle();
        read_check("R7 out of range port", 5);
        write(5'h1D, 16'hDC02); wait_idle();
        read_check("R7 out of range index", 20);

        // R8 wrap and R9 pair
        pulse(1, 3, MASK + 6);
        pulse(0, 1, 9);
        pulse(0, 0, MASK + 4);
        write(5'h1D, 16'hDC01); wait_idle();
        read_check("R8 wrap", 3);
        chk("R8 wrapped value", exp_lo, 5);
        write(5'h1D, 16'hDC00); wait_idle();
        read_check("R9 pair low half", 0);
        chk("R9 low value", exp_lo, 3);
        read_check("R9 pair high half", 1);
        chk("R9 high value", exp_lo, 1);

        // Random mix
        for (int it = 0; it < 60; it++) begin
            int n;
            n = $urandom_range(1, 8);
            for (int k = 0; k < n; k++) begin
                inc = NC*NP'($urandom); cycle();
            end
            inc = '0;
            write(5'h1D, 16'hDC00 | 16'($urandom_range(0, NP)));
            if ($urandom_range(0, 1) == 1) begin
                inc = NC*NP'($urandom); cycle(); inc = '0;
            end
            wait_idle();
            read_check("R3 R4 random", $urandom_range(0, NC));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule